// File: doc/BRIEF.md
# Thermal-Gated Priority Bus Arbiter

This block decides which of several bus masters owns a shared bus. Each master has a request line and receives a one-hot grant line. When the bus is free, the arbiter grants it to the pending request with the highest effective priority. The priority values come from an external table that a separate thermal-control agent rewrites at run time. A master that is running hot gets a lower value, so it wins the bus less often and stalls more. The arbiter reads the table on each decision. The logic that rewrites the table sits outside the decision path, so it adds no cycles to a grant.

Each master has a wait counter, so a master that has been pushed down the table still reaches the bus. A request that has waited longer than a set limit beats any priority. A single emergency input stops all bus traffic while it is high. The chip raises it when temperatures approach the absolute limit. The arbiter removes a grant that is live on the next edge and issues no new grant until the input is released.

Top module: `thermal_prio_arbiter`

## Requirements
- R1: Bit i of `gnt_o` is the grant to master i. At most one bit of `gnt_o` is high in any cycle. `gnt_o` is all zero while `rst_n` is low, with the reset acting asynchronously.
- R2: When the bus is free, no emergency is active and no request has timed out, the next edge grants the pending master with the largest priority value. Master i's priority is `prio_i[i*PRIO_W +: PRIO_W]`, and a larger value means a higher priority.
- R3: Among pending masters that share the largest priority value, the lowest master index is granted.
- R4: A grant appears on the edge that samples the request. It then stays on the same master for as long as that master keeps its request high, even when requests with a higher priority arrive.
- R5: When the granted master lowers its request, `gnt_o` goes to zero at the next edge. A new decision is made at the edge after that.
- R6: If the bus is free, `halt_i` is low and at least one request is high, some master is granted at the next edge, whatever the priority values are.
- R7: A master's wait count increases on each edge where its request is high and it is not granted. The count clears when the master is granted or its request is low. A pending request whose count exceeds `AGE_LIMIT` is granted ahead of any priority. A count equal to `AGE_LIMIT` does not override priority.
- R8: When several pending requests have timed out, the one with the largest wait count wins, and equal counts go to the lower index. Counts saturate at 2^WAIT_W-1, where WAIT_W = clog2(AGE_LIMIT+1)+1, and saturated counts compare as equal.
- R9: While `halt_i` is high, no grant is issued. A grant that is live when `halt_i` is sampled high is removed at that edge.
- R10: A change to `prio_i` takes effect in the very next decision, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_MASTERS | Request from each master |
| prio_i | input | N_MASTERS*PRIO_W | Run-time priority table, one field per master |
| halt_i | input | 1 | Emergency stop for all grants |
| gnt_o | output | N_MASTERS | One-hot grant to each master |

## Verification
The assertions assume that a master holds its request until it has been granted and then drops it to release the bus. They also assume that `prio_i` and `halt_i` are stable around the sampling edge. The bench drives every input on the falling clock edge and checks the grant on the next falling edge. It drops a request only to end a transfer or to show that a wait count clears. The aging scenarios let the counts pass the limit in a controlled way, by holding the bus with a high-priority owner for a known number of cycles. Those counts include one exactly at the limit, counts that differ, equal counts, and counts that saturate.

// File: rtl/thpa_pkg.sv
package thpa_pkg;
   // Source of the grant decision made on an idle bus.
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PRIO = 2'd1,
      SRC_AGED = 2'd2
   } grant_src_e;
endpackage

// File: rtl/thpa_wait_track.sv
module thpa_wait_track #(
   parameter int N_MASTERS = 8,
   parameter int WAIT_W    = 9,
   parameter int AGE_LIMIT = 255
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_MASTERS-1:0]          req_i,
   input  logic [N_MASTERS-1:0]          gnt_i,
   output logic [N_MASTERS*WAIT_W-1:0]   wait_o,
   output logic [N_MASTERS-1:0]          expired_o
);
   localparam logic [WAIT_W-1:0] CNT_MAX = '1;
   localparam logic [WAIT_W-1:0] CNT_LIM = WAIT_W'(AGE_LIMIT);

   for (genvar g = 0; g < N_MASTERS; g++) begin : g_cnt
      logic [WAIT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (!req_i[g] || gnt_i[g]) cnt_q <= '0;
         else if (cnt_q != CNT_MAX)     cnt_q <= cnt_q + 1'b1;
      end

      assign wait_o[g*WAIT_W +: WAIT_W] = cnt_q;
      // a stale count must not win once the request is gone
      assign expired_o[g] = req_i[g] && (cnt_q > CNT_LIM);

      // R8: the count holds at its ceiling
      a_r8_saturate : assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == CNT_MAX && req_i[g] && !gnt_i[g]) |=> cnt_q == CNT_MAX);

      // R7: a request that is not waiting leaves a zero count behind
      a_r7_clear : assert property (@(posedge clk) disable iff (!rst_n)
         (!req_i[g]) |=> cnt_q == '0);
   end
endmodule

// File: rtl/thpa_max_pick.sv
module thpa_max_pick #(
   parameter int N_MASTERS = 8,
   parameter int KEY_W     = 4,
   localparam int IDX_W    = $clog2(N_MASTERS)
) (
   input  logic [N_MASTERS-1:0]       valid_i,
   input  logic [N_MASTERS*KEY_W-1:0] key_i,
   output logic                       found_o,
   output logic [IDX_W-1:0]           idx_o
);
   logic [KEY_W-1:0] best;

   // Scan from the top index down; ">=" lets a lower index take over a tie.
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      best    = '0;
      for (int i = N_MASTERS - 1; i >= 0; i--) begin
         if (valid_i[i] && (!found_o || key_i[i*KEY_W +: KEY_W] >= best)) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
            best    = key_i[i*KEY_W +: KEY_W];
         end
      end
   end
endmodule

// File: rtl/thpa_grant_ctl.sv
module thpa_grant_ctl
   import thpa_pkg::*;
#(
   parameter int N_MASTERS = 8,
   localparam int IDX_W    = $clog2(N_MASTERS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic                 halt_i,
   input  logic                 aged_found_i,
   input  logic [IDX_W-1:0]     aged_idx_i,
   input  logic                 prio_found_i,
   input  logic [IDX_W-1:0]     prio_idx_i,
   output logic [N_MASTERS-1:0] gnt_o
);
   logic [N_MASTERS-1:0] gnt_q, gnt_d;
   logic                 bus_busy, owner_keeps;
   grant_src_e           src;
   logic [IDX_W-1:0]     win_idx;

   assign bus_busy    = |gnt_q;
   assign owner_keeps = |(gnt_q & req_i);

   always_comb begin
      if (aged_found_i)      src = SRC_AGED;
      else if (prio_found_i) src = SRC_PRIO;
      else                   src = SRC_NONE;
      win_idx = (src == SRC_AGED) ? aged_idx_i : prio_idx_i;
   end

   always_comb begin
      gnt_d = '0;
      if (halt_i)           gnt_d = '0;
      else if (owner_keeps) gnt_d = gnt_q;
      else if (bus_busy)    gnt_d = '0;
      else if (src != SRC_NONE) gnt_d[win_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= '0;
      else        gnt_q <= gnt_d;
   end

   assign gnt_o = gnt_q;

   a_r1_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q));

   a_r9_halt_clears : assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> gnt_q == '0);

   a_r4_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (owner_keeps && !halt_i) |=> gnt_q == $past(gnt_q));

   a_r5_release : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy && !owner_keeps) |=> gnt_q == '0);

   a_r6_work_conserving : assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_busy && !halt_i && |req_i) |=> gnt_q != '0);
endmodule

// File: rtl/thermal_prio_arbiter.sv
module thermal_prio_arbiter #(
   parameter int N_MASTERS = 8,
   parameter int PRIO_W    = 4,
   parameter int AGE_LIMIT = 255,
   parameter bit AGING_EN  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_MASTERS-1:0]          req_i,
   input  logic [N_MASTERS*PRIO_W-1:0]   prio_i,
   input  logic                          halt_i,
   output logic [N_MASTERS-1:0]          gnt_o
);
   localparam int IDX_W  = $clog2(N_MASTERS);
   localparam int WAIT_W = $clog2(AGE_LIMIT + 1) + 1;

   if (N_MASTERS < 2)  begin : g_bad_n   $error("N_MASTERS must be at least 2"); end
   if (PRIO_W < 1)     begin : g_bad_pw  $error("PRIO_W must be at least 1"); end
   if (AGE_LIMIT < 1)  begin : g_bad_age $error("AGE_LIMIT must be at least 1"); end

   logic                 prio_found, aged_found;
   logic [IDX_W-1:0]     prio_idx, aged_idx;
   logic [N_MASTERS-1:0] aged_mask;

   thpa_max_pick #(.N_MASTERS(N_MASTERS), .KEY_W(PRIO_W)) prio_pick_i (
      .valid_i (req_i),
      .key_i   (prio_i),
      .found_o (prio_found),
      .idx_o   (prio_idx)
   );

   if (AGING_EN) begin : g_aging
      logic [N_MASTERS*WAIT_W-1:0] wait_flat;

      thpa_wait_track #(.N_MASTERS(N_MASTERS), .WAIT_W(WAIT_W), .AGE_LIMIT(AGE_LIMIT)) wait_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_i     (req_i),
         .gnt_i     (gnt_o),
         .wait_o    (wait_flat),
         .expired_o (aged_mask)
      );

      thpa_max_pick #(.N_MASTERS(N_MASTERS), .KEY_W(WAIT_W)) aged_pick_i (
         .valid_i (aged_mask),
         .key_i   (wait_flat),
         .found_o (aged_found),
         .idx_o   (aged_idx)
      );

      // R7: a timed-out request beats priority on a free bus
      a_r7_aged_wins : assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_o == '0 && !halt_i && |aged_mask) |=> |(gnt_o & $past(aged_mask)));
   end else begin : g_no_aging
      assign aged_mask  = '0;
      assign aged_found = 1'b0;
      assign aged_idx   = '0;
   end

   thpa_grant_ctl #(.N_MASTERS(N_MASTERS)) ctl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .halt_i       (halt_i),
      .aged_found_i (aged_found),
      .aged_idx_i   (aged_idx),
      .prio_found_i (prio_found),
      .prio_idx_i   (prio_idx),
      .gnt_o        (gnt_o)
   );

   for (genvar a = 0; a < N_MASTERS; a++) begin : g_loser
      for (genvar b = 0; b < N_MASTERS; b++) begin : g_rival
         if (a != b) begin : g_cmp
            // R2: a strictly higher pending priority keeps master a out
            a_r2_higher_wins : assert property (@(posedge clk) disable iff (!rst_n)
               (gnt_o == '0 && !halt_i && aged_mask == '0 && req_i[b] &&
                prio_i[b*PRIO_W +: PRIO_W] > prio_i[a*PRIO_W +: PRIO_W]) |=> !gnt_o[a]);
         end
         if (b < a) begin : g_tie
            // R3: equal priority goes to the lower index
            a_r3_tie_low : assert property (@(posedge clk) disable iff (!rst_n)
               (gnt_o == '0 && !halt_i && aged_mask == '0 && req_i[b] &&
                prio_i[b*PRIO_W +: PRIO_W] == prio_i[a*PRIO_W +: PRIO_W]) |=> !gnt_o[a]);
         end
      end
   end
endmodule

// File: tb/thermal_prio_arbiter_tb_top.sv
module thermal_prio_arbiter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  req;
   logic [15:0] prio;
   logic        halt;
   logic [3:0]  gnt;
   int          n_chk = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   thermal_prio_arbiter #(.N_MASTERS(4), .PRIO_W(4), .AGE_LIMIT(6), .AGING_EN(1'b1)) dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req),
      .prio_i (prio),
      .halt_i (halt),
      .gnt_o  (gnt)
   );

   // {req, prio (master i at [4i+3:4i]), halt, expected grant after the edge}
   localparam int NV = 21;
   localparam logic [24:0] VECS [NV] = '{
      {4'b0000, 16'h2351, 1'b0, 4'b0000},  // 0  R1 idle
      {4'b0110, 16'h2351, 1'b0, 4'b0010},  // 1  R2 m1 prio 5 beats m2 prio 3
      {4'b0110, 16'h2351, 1'b0, 4'b0010},  // 2  R4 hold
      {4'b0100, 16'h2351, 1'b0, 4'b0000},  // 3  R5 release cycle
      {4'b0100, 16'h2351, 1'b0, 4'b0100},  // 4  R6 re-arbitrate
      {4'b0110, 16'h2351, 1'b0, 4'b0100},  // 5  R4 higher prio does not preempt
      {4'b0010, 16'h2351, 1'b0, 4'b0000},  // 6  R5
      {4'b0010, 16'h2351, 1'b0, 4'b0010},  // 7  R6
      {4'b0000, 16'h2351, 1'b0, 4'b0000},  // 8  R5
      {4'b1100, 16'h4444, 1'b0, 4'b0100},  // 9  R3 tie to lower index
      {4'b0000, 16'h4444, 1'b0, 4'b0000},  // 10
      {4'b0011, 16'h2351, 1'b0, 4'b0010},  // 11 R2
      {4'b0011, 16'h2351, 1'b0, 4'b0010},  // 12 R4
      {4'b0001, 16'h2351, 1'b0, 4'b0000},  // 13 R5
      {4'b0011, 16'h2357, 1'b0, 4'b0001},  // 14 R10 new table used at once
      {4'b0000, 16'h2357, 1'b0, 4'b0000},  // 15
      {4'b0001, 16'h2357, 1'b1, 4'b0000},  // 16 R9 no grant under halt
      {4'b0001, 16'h2357, 1'b0, 4'b0001},  // 17 R6
      {4'b0001, 16'h2357, 1'b1, 4'b0000},  // 18 R9 live grant removed
      {4'b0001, 16'h2357, 1'b1, 4'b0000},  // 19 R9
      {4'b0000, 16'h2357, 1'b0, 4'b0000}   // 20
   };

   task automatic check(input logic [3:0] exp, input string tag);
      n_chk++;
      if (gnt !== exp) begin
         n_bad++;
         $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
      end
   endtask

   // hold the inputs for n edges, ending on a falling edge
   task automatic run(input logic [3:0] r, input logic [15:0] p, input logic h, input int n);
      req = r; prio = p; halt = h;
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      for (int k = 0; k < 20000; k++) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: gnt=%b expected=run end", gnt);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; req = '0; prio = '0; halt = 1'b0;
      req = 4'b1111;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(4'b0000, "R1 reset");
      req = 4'b0000;
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         run(VECS[v][24:21], VECS[v][20:5], VECS[v][4], 1);
         check(VECS[v][3:0], $sformatf("vector %0d", v));
      end

      // R7: m3 waits 12, m1 waits 9, both beyond 6: the older m3 wins over m1's priority
      run(4'b0001, 16'h1059, 1'b0, 1); check(4'b0001, "R7 owner");
      run(4'b1001, 16'h1059, 1'b0, 3);
      run(4'b1011, 16'h1059, 1'b0, 8);
      run(4'b1010, 16'h1059, 1'b0, 1); check(4'b0000, "R5 owner drop");
      run(4'b1010, 16'h1059, 1'b0, 1); check(4'b1000, "R7 aged beats priority");
      run(4'b0000, 16'h1059, 1'b0, 2);

      // R7 boundary: m3 count equal to the limit does not override
      run(4'b0001, 16'h1059, 1'b0, 1);
      run(4'b1001, 16'h1059, 1'b0, 3);
      run(4'b1011, 16'h1059, 1'b0, 2);
      run(4'b1010, 16'h1059, 1'b0, 1);
      run(4'b1010, 16'h1059, 1'b0, 1); check(4'b0010, "R7 at limit, priority decides");
      run(4'b0000, 16'h1059, 1'b0, 2);

      // R8: equal counts of 9, m3 has higher priority but m1 is lower index
      run(4'b0001, 16'h5019, 1'b0, 1);
      run(4'b1011, 16'h5019, 1'b0, 8);
      run(4'b1010, 16'h5019, 1'b0, 1);
      run(4'b1010, 16'h5019, 1'b0, 1); check(4'b0010, "R8 equal age to lower index");
      run(4'b0000, 16'h5019, 1'b0, 2);

      // R8 saturation: counts 24 and 21 both clamp at 15, so they tie
      run(4'b0001, 16'h5019, 1'b0, 1);
      run(4'b1001, 16'h5019, 1'b0, 3);
      run(4'b1011, 16'h5019, 1'b0, 20);
      run(4'b1010, 16'h5019, 1'b0, 1);
      run(4'b1010, 16'h5019, 1'b0, 1); check(4'b0010, "R8 saturated counts tie");
      run(4'b0000, 16'h5019, 1'b0, 2);

      // R7: a dropped request clears its count, so no aged win afterwards
      run(4'b0001, 16'h1059, 1'b0, 1);
      run(4'b1001, 16'h1059, 1'b0, 10);
      run(4'b0011, 16'h1059, 1'b0, 1);
      run(4'b1010, 16'h1059, 1'b0, 1);
      run(4'b1010, 16'h1059, 1'b0, 1); check(4'b0010, "R7 count cleared by drop");
      run(4'b0000, 16'h1059, 1'b0, 2);

      // R1: asynchronous reset removes a live grant
      run(4'b0100, 16'h1059, 1'b0, 1); check(4'b0100, "R6 grant before reset");
      #1 rst_n = 1'b0;
      #1 check(4'b0000, "R1 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      run(4'b0000, 16'h1059, 1'b0, 1); check(4'b0000, "R1 after reset");

      finish_run();
   end
endmodule